// File: doc/BRIEF.md
# Serial Configuration Register Bank with Sticky Fault Flags

This block is a serial slave that lets a host program a bank of 16-bit configuration registers and read them back. It also keeps a fault status register. Hardware elsewhere on the chip sets its flags with single-cycle pulses. Software can only clear them. The host frames each transaction with an active-high select. While the select is high, bits arrive on the serial data line and are sampled on rising serial clock edges. The transaction takes effect only when the select drops again.

All serial inputs cross into the system clock domain through two-flop synchronisers and edge detectors. The block is therefore used with a serial clock several times slower than the system clock. The configuration registers are also driven out as parallel buses to the logic they control. At reset, a default-value input loads them, standing in for stored configuration. The serial side has no back-pressure. The host paces the frame, so the block exposes no valid/ready pair. The parallel outputs are plain status-style buses that are valid every cycle.

Top module: `cfg_serial_regs`

## Requirements
- R1: A frame is 24 bits sent most significant first: one operation bit (0 = write, 1 = read), then a 7-bit register address, then 16 data bits.
- R2: Bits are captured on rising serial clock edges only while select is high. A write frame changes the addressed register when select falls, and the new value shows on the parallel outputs within 6 system clock cycles of the select pin falling.
- R3: Serial clock edges after the 24th in a frame are ignored. A frame that ends with fewer than 24 edges changes nothing.
- R4: The spacing between bits within a frame is free, so a frame sent as three 8-bit pieces with long pauses behaves like a continuous one.
- R5: In a read frame the 16 data bits on the input are ignored. The addressed register's contents are driven on the data-out line, most significant bit first, and each bit changes after a falling serial clock edge so it is stable for the next rising edge. Data-out is 0 while select is low.
- R6: Configuration registers live at addresses 0 to NREG-1 and the fault register lives at 0x2A. Writes to any other address are discarded, and reads from them return 0.
- R7: Writing the fault register clears each flag whose data bit is 0 and leaves flags whose data bit is 1 untouched. Fault bits 15 to 6 read as 0.
- R8: A pulse on a fault set input sets the matching flag on the next system clock edge, and the flag stays set until it is cleared.
- R9: After a synchronous reset the fault flags read 0x18 (bits 4 and 3 set), every configuration register holds its slice of the default input, and data-out is 0.
- R10: When a hardware set and a software clear reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Frame select, active high |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| fault_set | input | FAULT_W | Per-flag set pulses from hardware |
| dflt_cfg | input | NREG*16 | Reset values of the configuration registers, register i in bits 16*i+15 to 16*i |
| cfg_out | output | NREG*16 | Configuration register contents, same packing as the default input |
| fault_out | output | FAULT_W | Fault flag contents |

## Verification
Each pin change needs two synchroniser flops and one edge-detect compare before the logic sees it. As a result, a read bit shows on data-out about four system cycles after the falling serial edge. The bench holds every serial clock level for six system cycles, so it samples data-out just before it raises the clock, and that bit is settled by then. A committed write needs one more register stage before it reaches the register bank, so it appears on the parallel outputs within six cycles of the select falling, and the bench compares them eight cycles later. A fault set pulse shows on the outputs one cycle after its edge, and the bench checks it several cycles after removing the pulse.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 16;
  localparam int HDR_W   = 1 + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/cfgspi_sync.sv
module cfgspi_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] pipe [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d;
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= '0;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/cfgspi_frame_rx.sv
module cfgspi_frame_rx
  import cfgspi_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_lvl,
  input  logic               cs_fall,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic               sdi,
  input  logic [DATA_W-1:0]  rd_data,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               sdo,
  output logic               commit,
  output frame_t             frame_q,
  output logic [CNT_W-1:0]   bit_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] HDR  = CNT_W'(HDR_W);

  logic [STAGES-1:0]  sdi_pipe;
  logic               sdi_s;
  logic [FRAME_W-1:0] shreg;
  logic [DATA_W-1:0]  tx;
  logic               hdr_read;

  // data line delayed as far as clock and select, so a sampled bit lines up with its edge
  always_ff @(posedge clk) begin
    if (rst) sdi_pipe <= '0;
    else     sdi_pipe <= {sdi_pipe[STAGES-2:0], sdi};
  end
  assign sdi_s = sdi_pipe[STAGES-1];

  assign hdr_read = shreg[HDR_W-1];
  assign rd_addr  = shreg[ADDR_W-1:0];
  assign sdo      = tx[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bit_cnt <= '0;
      tx      <= '0;
      commit  <= 1'b0;
      frame_q <= '0;
    end else begin
      commit <= 1'b0;
      if (cs_fall) begin
        frame_q <= frame_t'(shreg);
        commit  <= (bit_cnt == LAST) && (shreg[FRAME_W-1] == OP_WRITE);
      end
      if (!cs_lvl) begin
        bit_cnt <= '0;
        tx      <= '0;
      end else begin
        if (sck_rise && (bit_cnt < LAST)) begin
          shreg   <= {shreg[FRAME_W-2:0], sdi_s};
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (sck_fall && (bit_cnt >= HDR) && (bit_cnt < LAST)) begin
          if (bit_cnt == HDR) tx <= hdr_read ? rd_data : '0;
          else                tx <= tx << 1;
        end
      end
    end
  end
endmodule

// File: rtl/cfgspi_regbank.sv
module cfgspi_regbank
  import cfgspi_pkg::*;
#(
  parameter int                NREG       = 8,
  parameter int                FAULT_W    = 6,
  parameter logic [ADDR_W-1:0] FAULT_ADDR = 7'h2A,
  parameter logic [FAULT_W-1:0] FAULT_RST = 6'h18
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NREG*DATA_W-1:0] dflt,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [FAULT_W-1:0]     fault_set,
  output logic [DATA_W-1:0]      rd_data,
  output logic [NREG*DATA_W-1:0] cfg_flat,
  output logic [FAULT_W-1:0]     fault_q
);
  logic [DATA_W-1:0]  regs [NREG];
  logic               fault_hit;
  logic [FAULT_W-1:0] fault_kept;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                     regs[i] <= dflt[i*DATA_W +: DATA_W];
      else if (wr_en && (wr_addr == ADDR_W'(i)))   regs[i] <= wr_data;
    end
    assign cfg_flat[i*DATA_W +: DATA_W] = regs[i];
  end

  // clear-only software path, hardware set ORed in last so it wins
  assign fault_hit  = wr_en && (wr_addr == FAULT_ADDR);
  assign fault_kept = fault_hit ? (fault_q & wr_data[FAULT_W-1:0]) : fault_q;

  always_ff @(posedge clk) begin
    if (rst) fault_q <= FAULT_RST;
    else     fault_q <= fault_kept | fault_set;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == FAULT_ADDR) rd_data = DATA_W'(fault_q);
    for (int i = 0; i < NREG; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
  end
endmodule

// File: rtl/cfg_serial_regs.sv
module cfg_serial_regs
  import cfgspi_pkg::*;
#(
  parameter int                 NREG        = 8,
  parameter int                 FAULT_W     = 6,
  parameter logic [ADDR_W-1:0]  FAULT_ADDR  = 7'h2A,
  parameter logic [FAULT_W-1:0] FAULT_RST   = 6'h18,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs,
  input  logic                   sclk,
  input  logic                   sdi,
  output logic                   sdo,
  input  logic [FAULT_W-1:0]     fault_set,
  input  logic [NREG*DATA_W-1:0] dflt_cfg,
  output logic [NREG*DATA_W-1:0] cfg_out,
  output logic [FAULT_W-1:0]     fault_out
);
  logic [1:0]        s_lvl, s_rise, s_fall;
  logic              cs_lvl;
  logic              wr_commit;
  frame_t            wr_frame;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  rx_cnt;

  cfgspi_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst(rst), .d({cs, sclk}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );
  assign cs_lvl = s_lvl[1];

  cfgspi_frame_rx #(.STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst),
    .cs_lvl(cs_lvl), .cs_fall(s_fall[1]),
    .sck_rise(s_rise[0]), .sck_fall(s_fall[0]),
    .sdi(sdi), .rd_data(rd_data), .rd_addr(rd_addr),
    .sdo(sdo), .commit(wr_commit), .frame_q(wr_frame), .bit_cnt(rx_cnt)
  );

  cfgspi_regbank #(
    .NREG(NREG), .FAULT_W(FAULT_W), .FAULT_ADDR(FAULT_ADDR), .FAULT_RST(FAULT_RST)
  ) u_bank (
    .clk(clk), .rst(rst), .dflt(dflt_cfg),
    .wr_en(wr_commit), .wr_addr(wr_frame.addr), .wr_data(wr_frame.data),
    .rd_addr(rd_addr), .fault_set(fault_set),
    .rd_data(rd_data), .cfg_flat(cfg_out), .fault_q(fault_out)
  );
endmodule

// File: rtl/cfgspi_checker.sv
module cfgspi_checker
  import cfgspi_pkg::*;
#(
  parameter int                 NREG       = 8,
  parameter int                 FAULT_W    = 6,
  parameter logic [ADDR_W-1:0]  FAULT_ADDR = 7'h2A,
  parameter logic [FAULT_W-1:0] FAULT_RST  = 6'h18
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cs_lvl,
  input logic                   sdo,
  input logic [FAULT_W-1:0]     fault_out,
  input logic [FAULT_W-1:0]     fault_set,
  input logic [NREG*DATA_W-1:0] cfg_out,
  input logic                   commit,
  input logic [ADDR_W-1:0]      commit_addr,
  input logic [CNT_W-1:0]       bit_cnt
);
  assert_fault_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (fault_out == FAULT_RST));

  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ((~fault_out & $past(fault_out)) != '0) |-> $past(commit && (commit_addr == FAULT_ADDR)));

  assert_fault_set_R8: assert property (@(posedge clk) disable iff (rst)
    (fault_set != '0) |=> ((fault_out & $past(fault_set)) == $past(fault_set)));

  assert_frame_len_R3: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(FRAME_W));

  assert_sdo_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(cs_lvl) |-> !sdo);

  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(commit && (int'(commit_addr) < NREG)) |=> $stable(cfg_out));
endmodule

bind cfg_serial_regs cfgspi_checker #(
  .NREG(NREG), .FAULT_W(FAULT_W), .FAULT_ADDR(FAULT_ADDR), .FAULT_RST(FAULT_RST)
) u_chk (
  .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .sdo(sdo),
  .fault_out(fault_out), .fault_set(fault_set), .cfg_out(cfg_out),
  .commit(wr_commit), .commit_addr(wr_frame.addr), .bit_cnt(rx_cnt)
);

// File: tb/tb_cfg_serial_regs.sv
module tb_cfg_serial_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 8;
  localparam int FW         = 6;
  localparam int HALF       = 6;
  localparam logic [6:0] FADDR = 7'h2A;

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [FW-1:0]      fault_set = '0;
  logic [NREG*16-1:0] dflt;
  logic               sdo;
  logic [NREG*16-1:0] cfg_out;
  logic [FW-1:0]      fault_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_cfg [NREG];
  logic [FW-1:0] exp_fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_regs #(.NREG(NREG)) dut (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .fault_set(fault_set), .dflt_cfg(dflt), .cfg_out(cfg_out), .fault_out(fault_out)
  );

  function automatic logic [15:0] dflt_val(int i);
    return 16'h5A00 ^ (16'(i) * 16'h0111);
  endfunction

  function automatic logic [15:0] exp_read(logic [6:0] a);
    if (a == FADDR) return {10'b0, exp_fault};
    if (int'(a) < NREG) return exp_cfg[int'(a)];
    return 16'h0;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < NREG; i++)
      check(req, {16'h0, cfg_out[i*16 +: 16]}, {16'h0, exp_cfg[i]});
    check(req, {26'h0, fault_out}, {26'h0, exp_fault});
  endtask

  task automatic frame(bit rd, logic [6:0] a, logic [15:0] d, int nbits, int extra,
                       int gap, output logic [15:0] rdata);
    logic [23:0] w;
    w = {rd, a, d};
    rdata = '0;
    cs = 1'b1;
    tick(HALF);
    for (int b = 0; b < nbits; b++) begin
      sdi = w[23-b];
      tick(HALF);
      if (b >= 8) rdata = {rdata[14:0], sdo};
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
      if (gap > 0 && (b % 8) == 7) tick(gap);
    end
    for (int e = 0; e < extra; e++) begin
      sdi = 1'b1;
      tick(HALF);
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
    cs = 1'b0;
    sdi = 1'b0;
    tick(8);
  endtask

  task automatic do_write(logic [6:0] a, logic [15:0] d, int gap);
    logic [15:0] unused_r;
    frame(1'b0, a, d, 24, 0, gap, unused_r);
    if (int'(a) < NREG) exp_cfg[int'(a)] = d;
    if (a == FADDR) exp_fault = exp_fault & d[FW-1:0];
  endtask

  task automatic do_read(string req, logic [6:0] a, logic [15:0] junk);
    logic [15:0] r;
    frame(1'b1, a, junk, 24, 0, 0, r);
    check(req, {16'h0, r}, {16'h0, exp_read(a)});
  endtask

  task automatic pulse_fault(logic [FW-1:0] v);
    fault_set = v;
    tick(1);
    fault_set = '0;
    exp_fault = exp_fault | v;
    tick(2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'd4242));
    for (int i = 0; i < NREG; i++) begin
      dflt[i*16 +: 16] = dflt_val(i);
      exp_cfg[i] = dflt_val(i);
    end
    exp_fault = 6'h18;
    tick(6);
    rst = 1'b0;
    tick(3);

    // R9 reset state
    check_all("R9");
    check("R9 sdo", {31'h0, sdo}, 32'h0);

    // R1 R2 continuous write frame
    do_write(7'd3, 16'hBEEF, 0);
    check_all("R1 R2");
    // R4 frame split into bytes with long pauses
    do_write(7'd5, 16'h1234, 40);
    check_all("R4");
    // R5 read with data bits set, they must not alter the register
    do_read("R5", 7'd3, 16'hFFFF);
    check_all("R5");
    do_read("R5", 7'd5, 16'h0000);
    check("R5 sdo idle", {31'h0, sdo}, 32'h0);
    // R6 undefined address
    do_read("R6", 7'h10, 16'h0);
    do_write(7'h10, 16'hFFFF, 0);
    check_all("R6");
    // R7 fault register read, write ones, clear one bit
    do_read("R7", FADDR, 16'h0);
    do_write(FADDR, 16'hFFFF, 0);
    check_all("R7");
    do_write(FADDR, 16'hFFF7, 0);
    check_all("R7");
    do_read("R7", FADDR, 16'h0);
    // R8 hardware set
    pulse_fault(6'h21);
    check_all("R8");
    // R3 short frame ignored
    frame(1'b0, 7'd0, 16'h0F0F, 20, 0, 0, r);
    check_all("R3");
    // R3 extra edges ignored
    frame(1'b0, 7'd1, 16'h00C3, 24, 5, 0, r);
    exp_cfg[1] = 16'h00C3;
    check_all("R3");
    // R10 set held across a clearing write
    fault_set = 6'h3F;
    frame(1'b0, FADDR, 16'h0000, 24, 0, 0, r);
    fault_set = '0;
    exp_fault = 6'h3F;
    tick(3);
    check_all("R10");
    do_write(FADDR, 16'h0000, 0);
    check_all("R7");

    for (int it = 0; it < 48; it++) begin
      logic [6:0] a;
      int sel;
      sel = $urandom % 3;
      if (sel == 0)      a = FADDR;
      else if (sel == 1) a = 7'($urandom % NREG);
      else               a = 7'h40 + 7'($urandom % 32);
      case ($urandom % 4)
        0: begin do_write(7'($urandom % NREG), 16'($urandom), 0); check_all("R2"); end
        1: begin do_write(a, 16'($urandom), ($urandom % 2) * 30); check_all("R6 R7"); end
        2: do_read("R5", a, 16'($urandom));
        default: begin pulse_fault(6'($urandom)); check_all("R8"); end
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule